// File: doc/BRIEF.md
# SPI Flash User-Mode Transfer Engine

This block lets software drive a single-bit SPI flash bus by hand. A small register bus holds one control word per chip and one configuration word. The control word picks a command mode and holds a stop-active bit. Software frames a transaction by flipping that bit while the chip sits in user mode, and chip select follows it.

Between the two control writes, software pushes bytes through a data window. A write of one, two or four bytes shifts those bytes out on MOSI. A read of the same widths clocks in that many bytes from MISO. The byte address inside the window only selects the byte lanes. All higher address bits are ignored, so the window acts as a byte FIFO onto the bus.

The window request is a valid/ready stream. `win_ready` is high only when the engine is idle. An accepted access holds `win_ready` low until its last bit has been shifted, so the requester is back-pressured for the whole access. There is never more than one access in flight. The read response is a single-cycle pulse on `rsp_valid` and cannot be stalled.

Top module: `spi_user_engine`

## Requirements
- R1: After reset, every `spi_cs_n` bit is high, `spi_sclk` is low and `win_ready` is high.
- R2: Register address 0 holds the configuration word; address 1+i holds the control word of chip i, with command mode in bits [1:0] (0 normal read, 1 fast read, 2 write, 3 user) and stop-active in bit 2. `spi_cs_n[i]` is low exactly when mode is 3 and bit 2 is 0; every other chip select stays high.
- R3: Writing mode 3 with stop-active set leaves chip select high, clearing stop-active drives it low, and setting it again (then writing a plain read mode) drives and keeps it high.
- R4: Bits go out MSB first in SPI mode 0: `spi_sclk` idles low, MOSI changes only while `spi_sclk` is low, 8 rising edges per byte, each half period lasting `HALF_DIV` clocks.
- R5: `win_size` encodes 0 = byte, 1 = halfword, 2 = word (3 is illegal). Write data sits in its address byte lanes and the bytes are sent in ascending address order: a word sends `wdata[7:0]` first, and a halfword at offset 2 sends `wdata[23:16]` then `wdata[31:24]`.
- R6: A read clocks in as many bytes as its size and returns them in one `rsp_valid` pulse. The first byte goes to the lowest addressed lane and unused lanes are zero.
- R7: Address bits above [1:0] have no effect on what goes out on the bus.
- R8: A misaligned access, or one with size code 3, is accepted and dropped with no SPI clock edge; a dropped read returns zero.
- R9: An access to chip i is dropped with no SPI clock edge unless configuration bit 16+i is set.
- R10: `win_ready` is low from acceptance of a transferring access until all its bits are shifted, and no `spi_sclk` edge occurs while `win_ready` is high.
- R11: An access to a chip whose select is not driven active (R2) is dropped with no SPI clock edge.
- R12: During a read, MOSI stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index: 0 configuration, 1+i chip i control |
| reg_wdata | input | 32 | Register write data |
| win_valid | input | 1 | Window access request valid |
| win_ready | output | 1 | Engine idle, request accepted when both high |
| win_write | input | 1 | 1 = write access, 0 = read access |
| win_cs | input | CS_W | Chip window addressed |
| win_size | input | 2 | Access size code |
| win_addr | input | WIN_AW | Byte offset inside the chip window |
| win_wdata | input | 32 | Lane-positioned write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 32 | Lane-positioned read data |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the engine with three chip selects, a two-clock half period and a 13-bit window offset. Three selects put the highest write-enable bit at position 18 and leave every chip with a neighbour whose select must not move. The two-clock half period makes the divider count instead of toggling every clock, so the measured 20 ns between rising edges checks that count. The wide offset lets accesses at far window addresses be compared with accesses at offset zero.

// File: rtl/spi_ue_pkg.sv
package spi_ue_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FAST   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_USER   = 2'd3
  } cmd_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT
  } seq_state_e;

  localparam int STOP_BIT = 2;

  typedef struct packed {
    logic [1:0] mode;
    logic       stop;
  } chip_ctl_t;

endpackage

// File: rtl/spi_ue_regs.sv
module spi_ue_regs
  import spi_ue_pkg::*;
#(
  parameter int NUM_CS  = 3,
  parameter int WE_BASE = 16,
  parameter int RA_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [NUM_CS-1:0] we_en,
  output logic [NUM_CS-1:0] user_act
);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_en <= '0;
    end else if (reg_wr && reg_addr == '0) begin
      we_en <= reg_wdata[WE_BASE +: NUM_CS];
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_chip
    chip_ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '{mode: MODE_NORMAL, stop: 1'b0};
      end else if (reg_wr && reg_addr == RA_W'(i + 1)) begin
        ctl_q.mode <= reg_wdata[1:0];
        ctl_q.stop <= reg_wdata[STOP_BIT];
      end
    end

    assign user_act[i] = (ctl_q.mode == MODE_USER) && !ctl_q.stop;
  end

endmodule

// File: rtl/spi_ue_shift.sv
module spi_ue_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sclk  <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        tx_q  <= tx_byte;
        div_q <= '0;
        bit_q <= '0;
        sclk  <= 1'b0;
      end else if (busy) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx_q <= {rx_q[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_q == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign mosi    = busy & tx_q[7];
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi_ue_seq.sv
module spi_ue_seq
  import spi_ue_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2,
  parameter int WIN_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  output logic              win_ready,
  input  logic              win_write,
  input  logic [CS_W-1:0]   win_cs,
  input  logic [1:0]        win_size,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [31:0]       win_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NUM_CS-1:0] we_en,
  input  logic [NUM_CS-1:0] user_act,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);

  seq_state_e state_q;
  logic [1:0]  lane_q;
  logic [2:0]  left_q;
  logic [31:0] wbuf_q;
  logic [31:0] rbuf_q;
  logic        wr_q;

  logic        unused_addr;
  assign unused_addr = ^win_addr[WIN_AW-1:2];

  logic        aligned;
  logic        chip_ok;
  logic        go;
  logic [2:0]  nbytes;
  logic [31:0] rmerge;

  always_comb begin
    unique case (acc_size_e'(win_size))
      SZ_BYTE: begin aligned = 1'b1;               nbytes = 3'd1; end
      SZ_HALF: begin aligned = !win_addr[0];       nbytes = 3'd2; end
      SZ_WORD: begin aligned = win_addr[1:0] == 0; nbytes = 3'd4; end
      default: begin aligned = 1'b0;               nbytes = 3'd0; end
    endcase
  end

  assign chip_ok = (int'(win_cs) < NUM_CS) && we_en[win_cs] && user_act[win_cs];
  assign go      = aligned && chip_ok;

  assign win_ready = (state_q == SQ_IDLE);
  assign sh_start  = (state_q == SQ_LOAD);
  assign sh_tx     = wr_q ? wbuf_q[lane_q*8 +: 8] : 8'h00;

  always_comb begin
    rmerge = rbuf_q;
    rmerge[lane_q*8 +: 8] = sh_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      lane_q    <= '0;
      left_q    <= '0;
      wbuf_q    <= '0;
      rbuf_q    <= '0;
      wr_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (win_valid) begin
            if (go) begin
              lane_q  <= win_addr[1:0];
              left_q  <= nbytes;
              wbuf_q  <= win_wdata;
              rbuf_q  <= '0;
              wr_q    <= win_write;
              state_q <= SQ_LOAD;
            end else begin
              rsp_valid <= !win_write;
              rsp_rdata <= '0;
            end
          end
        end
        SQ_LOAD: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (sh_done) begin
            rbuf_q <= rmerge;
            lane_q <= lane_q + 2'd1;
            left_q <= left_q - 3'd1;
            if (left_q == 3'd1) begin
              state_q   <= SQ_IDLE;
              rsp_valid <= !wr_q;
              rsp_rdata <= rmerge;
            end else begin
              state_q <= SQ_LOAD;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_user_engine.sv
module spi_user_engine #(
  parameter int NUM_CS   = 3,
  parameter int HALF_DIV = 2,
  parameter int WE_BASE  = 16,
  parameter int WIN_AW   = 13,
  localparam int RA_W    = $clog2(NUM_CS + 1),
  localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              win_valid,
  output logic              win_ready,
  input  logic              win_write,
  input  logic [CS_W-1:0]   win_cs,
  input  logic [1:0]        win_size,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [31:0]       win_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  logic [NUM_CS-1:0] we_en;
  logic [NUM_CS-1:0] user_act;
  logic              sh_start;
  logic [7:0]        sh_tx;
  logic              sh_busy;
  logic              sh_done;
  logic [7:0]        sh_rx;

  spi_ue_regs #(
    .NUM_CS (NUM_CS),
    .WE_BASE(WE_BASE),
    .RA_W   (RA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .we_en    (we_en),
    .user_act (user_act)
  );

  spi_ue_seq #(
    .NUM_CS(NUM_CS),
    .CS_W  (CS_W),
    .WIN_AW(WIN_AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_valid(win_valid),
    .win_ready(win_ready),
    .win_write(win_write),
    .win_cs   (win_cs),
    .win_size (win_size),
    .win_addr (win_addr),
    .win_wdata(win_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .we_en    (we_en),
    .user_act (user_act),
    .sh_start (sh_start),
    .sh_tx    (sh_tx),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx)
  );

  spi_ue_shift #(
    .HALF_DIV(HALF_DIV)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .tx_byte(sh_tx),
    .miso   (spi_miso),
    .busy   (sh_busy),
    .done   (sh_done),
    .rx_byte(sh_rx),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi)
  );

  logic unused_busy;
  assign unused_busy = sh_busy;

  assign spi_cs_n = ~user_act;

endmodule

// File: rtl/spi_user_engine_chk.sv
module spi_user_engine_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_ready,
  input logic              rsp_valid,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);

  assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  assert_idle_sclk_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !spi_sclk);

  assert_rsp_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> win_ready);

  assert_edge_needs_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !(&spi_cs_n));

endmodule

bind spi_user_engine spi_user_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .win_ready(win_ready),
  .rsp_valid(rsp_valid),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n)
);

// File: tb/test_spi_user_engine.sv
`timescale 1ns/1ps
module test_spi_user_engine;
  localparam int NCS = 3;
  localparam int HD  = 2;
  localparam int AW  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic win_valid = 1'b0;
  logic win_ready;
  logic win_write = 1'b0;
  logic [1:0] win_cs = '0;
  logic [1:0] win_size = '0;
  logic [AW-1:0] win_addr = '0;
  logic [31:0] win_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_user_engine #(.NUM_CS(NCS), .HALF_DIV(HD), .WIN_AW(AW)) i_spi_user_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .win_valid(win_valid), .win_ready(win_ready),
    .win_write(win_write), .win_cs(win_cs), .win_size(win_size),
    .win_addr(win_addr), .win_wdata(win_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // bus monitor and flash model
  logic mon_bits [0:4095];
  int mon_cnt = 0;
  int base = 0;
  logic [7:0] sl_bytes [0:3];
  realtime t_rise [0:1];

  always @(posedge spi_sclk) begin
    mon_bits[mon_cnt & 4095] <= spi_mosi;
    if (mon_cnt - base < 2) t_rise[mon_cnt - base] <= $realtime;
    mon_cnt <= mon_cnt + 1;
  end

  assign spi_miso = sl_bytes[((mon_cnt - base) >> 3) & 3][7 - ((mon_cnt - base) & 7)];

  function automatic logic [7:0] got_byte(int k);
    logic [7:0] v = '0;
    for (int b = 0; b < 8; b++) v = {v[6:0], mon_bits[(base + 8*k + b) & 4095]};
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    base = mon_cnt;
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic access(bit wr, int cs, int sz, int addr, logic [31:0] wd,
                        output logic [31:0] rd, output bit got_rsp,
                        output bit low_seen, output int edges_at_ready);
    got_rsp = 0; low_seen = 0; rd = '0;
    @(negedge clk);
    win_valid = 1'b1; win_write = wr; win_cs = 2'(cs); win_size = 2'(sz);
    win_addr = AW'(addr); win_wdata = wd;
    while (!win_ready) @(negedge clk);
    @(negedge clk);
    win_valid = 1'b0;
    forever begin
      if (rsp_valid) begin got_rsp = 1; rd = rsp_rdata; end
      if (win_ready) break;
      low_seen = 1;
      @(negedge clk);
    end
    edges_at_ready = mon_cnt - base;
  endtask

  logic [31:0] rd;
  bit rsp, low;
  int ed;

  task automatic t_reset();
    check(spi_cs_n == 3'b111, "R1 cs_n", 32'(spi_cs_n), 32'h7);
    check(spi_sclk == 1'b0, "R1 sclk", 32'(spi_sclk), 0);
    check(win_ready == 1'b1, "R1 ready", 32'(win_ready), 1);
  endtask

  task automatic t_cs_frame();
    wreg(2, 32'h7);
    @(negedge clk);
    check(spi_cs_n[1] == 1'b1, "R3 user+stop keeps cs high", 32'(spi_cs_n), 32'h7);
    wreg(2, 32'h3);
    @(negedge clk);
    check(spi_cs_n == 3'b101, "R2 R3 cs1 active only", 32'(spi_cs_n), 32'h5);
    wreg(2, 32'h1);
    check(spi_cs_n == 3'b111, "R2 fast-read mode inactive", 32'(spi_cs_n), 32'h7);
    wreg(2, 32'h3);
    wreg(2, 32'h7);
    check(spi_cs_n[1] == 1'b1, "R3 stop set ends frame", 32'(spi_cs_n), 32'h7);
    wreg(2, 32'h0);
    check(spi_cs_n == 3'b111, "R3 plain read mode", 32'(spi_cs_n), 32'h7);
  endtask

  task automatic t_byte_write();
    wreg(0, 32'h0001_0000);
    wreg(1, 32'h7); wreg(1, 32'h3);
    check(spi_cs_n == 3'b110, "R2 cs0 active", 32'(spi_cs_n), 32'h6);
    clr_mon();
    access(1, 0, 0, 0, 32'h0000_00A5, rd, rsp, low, ed);
    check(ed == 8, "R4 eight edges", 32'(ed), 8);
    check(got_byte(0) == 8'hA5, "R4 msb first", 32'(got_byte(0)), 32'hA5);
    check(t_rise[1] - t_rise[0] == 2.0 * HD * 5.0, "R4 half period",
          32'(int'(t_rise[1] - t_rise[0])), 32'(2 * HD * 5));
    check(rsp == 0, "R6 no rsp on write", 32'(rsp), 0);
  endtask

  task automatic t_multi_write();
    clr_mon();
    access(1, 0, 2, 0, 32'h4433_2211, rd, rsp, low, ed);
    check(low == 1, "R10 ready low during access", 32'(low), 1);
    check(ed == 32, "R10 all bits out at ready", 32'(ed), 32);
    check({got_byte(3), got_byte(2), got_byte(1), got_byte(0)} == 32'h4433_2211,
          "R5 word order", {got_byte(3), got_byte(2), got_byte(1), got_byte(0)}, 32'h4433_2211);
    clr_mon();
    access(1, 0, 1, 2, 32'hBEEF_0000, rd, rsp, low, ed);
    check(ed == 16 && got_byte(0) == 8'hEF && got_byte(1) == 8'hBE, "R5 half at offset 2",
          {8'(ed), 8'h0, got_byte(1), got_byte(0)}, 32'h1000_BEEF);
  endtask

  task automatic t_reads();
    sl_bytes[0] = 8'h12; sl_bytes[1] = 8'h34; sl_bytes[2] = 8'h56; sl_bytes[3] = 8'h78;
    clr_mon();
    access(0, 0, 2, 0, 32'hFFFF_FFFF, rd, rsp, low, ed);
    check(rsp && rd == 32'h7856_3412, "R6 word read", rd, 32'h7856_3412);
    check(ed == 32, "R6 32 edges", 32'(ed), 32);
    check({got_byte(3), got_byte(2), got_byte(1), got_byte(0)} == 0, "R12 mosi low on read",
          {got_byte(3), got_byte(2), got_byte(1), got_byte(0)}, 0);
    sl_bytes[0] = 8'h9A; sl_bytes[1] = 8'hBC;
    clr_mon();
    access(0, 0, 1, 2, 32'h0, rd, rsp, low, ed);
    check(rsp && rd == 32'hBC9A_0000 && ed == 16, "R6 half read lanes", rd, 32'hBC9A_0000);
  endtask

  task automatic t_offset();
    clr_mon();
    access(1, 0, 0, 13'h1F00, 32'h0000_005C, rd, rsp, low, ed);
    check(ed == 8 && got_byte(0) == 8'h5C, "R7 high offset ignored", 32'(got_byte(0)), 32'h5C);
    clr_mon();
    access(1, 0, 0, 13'h1F01, 32'h0000_C300, rd, rsp, low, ed);
    check(ed == 8 && got_byte(0) == 8'hC3, "R7 lane 1 at high offset", 32'(got_byte(0)), 32'hC3);
  endtask

  task automatic t_drops();
    clr_mon();
    access(1, 0, 1, 1, 32'h1234_5678, rd, rsp, low, ed);
    check(ed == 0 && low == 0, "R8 misaligned write dropped", 32'(ed), 0);
    access(0, 0, 2, 2, 32'h0, rd, rsp, low, ed);
    check(ed == 0 && rsp && rd == 0, "R8 misaligned read zero", rd, 0);
    access(1, 0, 3, 0, 32'hFFFF_FFFF, rd, rsp, low, ed);
    check(ed == 0, "R8 size code 3 dropped", 32'(ed), 0);
    wreg(3, 32'h7); wreg(3, 32'h3);
    clr_mon();
    access(1, 2, 0, 0, 32'h0000_0081, rd, rsp, low, ed);
    check(ed == 0, "R9 write enable clear drops", 32'(ed), 0);
    wreg(0, 32'h0005_0000);
    clr_mon();
    access(1, 2, 0, 0, 32'h0000_0081, rd, rsp, low, ed);
    check(ed == 8 && got_byte(0) == 8'h81, "R9 bit 18 enables chip 2", 32'(ed), 8);
    wreg(3, 32'h7); wreg(3, 32'h0);
    clr_mon();
    access(1, 2, 0, 0, 32'h0000_0081, rd, rsp, low, ed);
    check(ed == 0, "R11 chip not in user mode dropped", 32'(ed), 0);
    access(1, 1, 0, 0, 32'h0000_0081, rd, rsp, low, ed);
    check(ed == 0, "R11 chip 1 select inactive", 32'(ed), 0);
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) sl_bytes[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cs_frame();
    t_byte_write();
    t_multi_write();
    t_reads();
    t_offset();
    t_drops();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule